// File: doc/BRIEF.md
# Hardware Thread Context Enable Scheduler

This block keeps track of which of a small set of resident hardware thread contexts may run. It also chooses the next runnable one when the processor switches away from the current thread. Each context owns a pair of register windows, so the current context is named by a window pointer whose upper bits are the context number. A per-context disable mask gates the choice. A context is disabled when its thread takes a cache-miss or failed-synchronization trap. It is enabled again by a hardware completion strobe that carries the context number, and software may also overwrite the whole mask.

A switch is carried out by a one-cycle search instruction that walks the window ring either upward or downward. It stops at the first context whose mask bit is clear. If none qualifies, the window pointer is left where it is and nothing is signalled. When every context is disabled, the block raises an idle indication and counts the idle cycles.

Top module: `ctx_sched`

## Requirements
- R1: After reset the window pointer is 0, every mask bit is 0, idle is low and the idle count is 0.
- R2: Mask bit i belongs to context i, and a 0 means enabled while a 1 means disabled. Context i owns windows 2i and 2i+1, and the window pointer bits [2:1] give the current context.
- R3: A forward search (op code 1) tries the pointer plus 2, then plus 4, then plus 6, modulo 8. The first enabled context among these becomes the new pointer in the next cycle.
- R4: A backward search (op code 2) tries the pointer minus 2, then minus 4, then minus 6, modulo 8, in that order. The pointer is updated in the next cycle.
- R5: If none of the other contexts is enabled, a search leaves the window pointer unchanged.
- R6: A disable request sets the mask bit of the current context, and the change is visible in the next cycle.
- R7: A software mask write replaces the mask from the second cycle after the write. A search in the cycle directly after the write still sees the old mask.
- R8: A re-enable strobe clears the named context's mask bit. The change becomes visible exactly 4 cycles after the strobe cycle, and the mask is unaffected before then.
- R9: When a maturing re-enable and a disable request, or a maturing re-enable and a software write, reach the same mask bit at the same edge, the re-enable wins and the bit ends up 0.
- R10: Idle is high exactly while all four mask bits are 1. The idle count rises by one for each idle cycle and saturates at its maximum.
- R11: Op code 3 performs no search and leaves the window pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| srch_op_i | input | 2 | Search op: 0 none, 1 forward, 2 backward, 3 reserved |
| trap_dis_i | input | 1 | Disable the current context |
| sw_wr_i | input | 1 | Software mask write strobe |
| sw_mask_i | input | 4 | Software mask value |
| rel_stb_i | input | 1 | Hardware re-enable strobe |
| rel_ctx_i | input | 2 | Context number to re-enable |
| cwp_o | output | 3 | Current window pointer |
| mask_o | output | 4 | Disable mask, bit per context |
| idle_o | output | 1 | All contexts disabled |
| idle_cnt_o | output | CNT_W (16) | Saturating idle-cycle count |

## Verification
The collisions of interest are a re-enable strobe that matures on the same edge as a disable trap for that context, and a matured strobe that meets a pending software mask write. The bench provokes the first by issuing a strobe for the current context and raising the trap exactly three cycles later. It provokes the second by timing a full-ones mask write so that its delay slot ends on the strobe's landing edge. In both cases the cycle-accurate reference model must show the contested bit clear while every other bit follows the trap or the write.

// File: rtl/ctx_sched_pkg.sv
package ctx_sched_pkg;

  typedef enum logic [1:0] {
    SRCH_NONE = 2'd0,
    SRCH_FWD  = 2'd1,
    SRCH_BWD  = 2'd2,
    SRCH_RSVD = 2'd3
  } srch_op_e;

endpackage

// File: rtl/ctx_mask_file.sv
module ctx_mask_file #(
  parameter int NUM_CTX   = 4,
  parameter int ENA_DELAY = 4,
  localparam int CTX_W    = $clog2(NUM_CTX),
  localparam int STAGES   = ENA_DELAY - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trap_i,
  input  logic [CTX_W-1:0]   trap_ctx_i,
  input  logic               sw_wr_i,
  input  logic [NUM_CTX-1:0] sw_mask_i,
  input  logic               rel_stb_i,
  input  logic [CTX_W-1:0]   rel_ctx_i,
  output logic [NUM_CTX-1:0] mask_o
);

  logic [NUM_CTX-1:0] mask_q, mask_d;
  logic               swp_vld_q;
  logic [NUM_CTX-1:0] swp_val_q;
  logic [STAGES-1:0]  rp_vld_q;
  logic [CTX_W-1:0]   rp_ctx_q [STAGES];
  logic               land_vld;
  logic [CTX_W-1:0]   land_ctx;

  assign land_vld = rp_vld_q[STAGES-1];
  assign land_ctx = rp_ctx_q[STAGES-1];

  // software write staging (delay slot)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swp_vld_q <= 1'b0;
      swp_val_q <= '0;
    end else begin
      swp_vld_q <= sw_wr_i;
      if (sw_wr_i) swp_val_q <= sw_mask_i;
    end
  end

  // re-enable delay pipeline
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp_vld_q[0] <= 1'b0;
      rp_ctx_q[0] <= '0;
    end else begin
      rp_vld_q[0] <= rel_stb_i;
      if (rel_stb_i) rp_ctx_q[0] <= rel_ctx_i;
    end
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_rel_pipe
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rp_vld_q[s] <= 1'b0;
          rp_ctx_q[s] <= '0;
        end else begin
          rp_vld_q[s] <= rp_vld_q[s-1];
          if (rp_vld_q[s-1]) rp_ctx_q[s] <= rp_ctx_q[s-1];
        end
      end
    end
  endgenerate

  // mask next state: software base, trap sets, landing re-enable clears last
  always_comb begin
    mask_d = swp_vld_q ? swp_val_q : mask_q;
    if (trap_i)   mask_d[trap_ctx_i] = 1'b1;
    if (land_vld) mask_d[land_ctx]   = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  // R8: a landing re-enable leaves its context enabled
  a_r8_reenable_lands: assert property (@(posedge clk) disable iff (!rst_n)
    land_vld |=> !mask_q[$past(land_ctx)]);

  // R6: a trap without a colliding re-enable disables its context
  a_r6_trap_disables: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_i && !(land_vld && land_ctx == trap_ctx_i)) |=> mask_q[$past(trap_ctx_i)]);

  // R7: an undisturbed software write is the mask two cycles later
  a_r7_sw_write_slot: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_i ##1 (!trap_i && !land_vld && !sw_wr_i) |=> (mask_q == $past(sw_mask_i, 2)));

endmodule

// File: rtl/ctx_search.sv
module ctx_search #(
  parameter int NUM_CTX = 4,
  localparam int CTX_W  = $clog2(NUM_CTX)
) (
  input  logic [CTX_W-1:0]   cur_ctx_i,
  input  logic               dir_bwd_i,
  input  logic [NUM_CTX-1:0] mask_i,
  output logic               hit_o,
  output logic [CTX_W-1:0]   ctx_o
);

  logic [CTX_W-1:0] cand [NUM_CTX-1];

  generate
    for (genvar k = 1; k < NUM_CTX; k++) begin : g_cand
      assign cand[k-1] = dir_bwd_i ? (cur_ctx_i - CTX_W'(k)) : (cur_ctx_i + CTX_W'(k));
    end
  endgenerate

  // nearest candidate has priority: scan from farthest to nearest
  always_comb begin
    hit_o = 1'b0;
    ctx_o = cur_ctx_i;
    for (int j = NUM_CTX - 2; j >= 0; j--) begin
      if (!mask_i[cand[j]]) begin
        hit_o = 1'b1;
        ctx_o = cand[j];
      end
    end
  end

endmodule

// File: rtl/ctx_idle_count.sv
module ctx_idle_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = idle_i && (cnt_q != '1);

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R10: count holds at its ceiling
  a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '1) |=> (cnt_q == '1));

  // R10: count never moves while not idle
  a_r10_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_i |=> $stable(cnt_q));

endmodule

// File: rtl/ctx_sched.sv
module ctx_sched
  import ctx_sched_pkg::*;
#(
  parameter int NUM_CTX     = 4,
  parameter int WIN_PER_CTX = 2,
  parameter int ENA_DELAY   = 4,
  parameter int CNT_W       = 16,
  localparam int CTX_W      = $clog2(NUM_CTX),
  localparam int WIN_LSB    = $clog2(WIN_PER_CTX),
  localparam int PTR_W      = CTX_W + WIN_LSB
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         srch_op_i,
  input  logic               trap_dis_i,
  input  logic               sw_wr_i,
  input  logic [NUM_CTX-1:0] sw_mask_i,
  input  logic               rel_stb_i,
  input  logic [CTX_W-1:0]   rel_ctx_i,
  output logic [PTR_W-1:0]   cwp_o,
  output logic [NUM_CTX-1:0] mask_o,
  output logic               idle_o,
  output logic [CNT_W-1:0]   idle_cnt_o
);

  srch_op_e           op;
  logic [PTR_W-1:0]   cwp_q, cwp_d;
  logic [CTX_W-1:0]   cur_ctx;
  logic [NUM_CTX-1:0] mask;
  logic               do_srch;
  logic               srch_hit;
  logic [CTX_W-1:0]   srch_ctx;

  assign op      = srch_op_e'(srch_op_i);
  assign do_srch = (op == SRCH_FWD) || (op == SRCH_BWD);
  assign cur_ctx = cwp_q[PTR_W-1:WIN_LSB];

  ctx_mask_file #(
    .NUM_CTX   (NUM_CTX),
    .ENA_DELAY (ENA_DELAY)
  ) u_mask (
    .clk        (clk),
    .rst_n      (rst_n),
    .trap_i     (trap_dis_i),
    .trap_ctx_i (cur_ctx),
    .sw_wr_i    (sw_wr_i),
    .sw_mask_i  (sw_mask_i),
    .rel_stb_i  (rel_stb_i),
    .rel_ctx_i  (rel_ctx_i),
    .mask_o     (mask)
  );

  ctx_search #(
    .NUM_CTX (NUM_CTX)
  ) u_search (
    .cur_ctx_i (cur_ctx),
    .dir_bwd_i (op == SRCH_BWD),
    .mask_i    (mask),
    .hit_o     (srch_hit),
    .ctx_o     (srch_ctx)
  );

  ctx_idle_count #(
    .CNT_W (CNT_W)
  ) u_idle (
    .clk    (clk),
    .rst_n  (rst_n),
    .idle_i (idle_o),
    .cnt_o  (idle_cnt_o)
  );

  always_comb begin
    cwp_d = cwp_q;
    if (do_srch && srch_hit) cwp_d = {srch_ctx, cwp_q[WIN_LSB-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cwp_q <= '0;
    else        cwp_q <= cwp_d;
  end

  assign cwp_o  = cwp_q;
  assign mask_o = mask;
  assign idle_o = &mask;

  // R3/R4: a search only ever selects an enabled context
  a_r3_pick_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (do_srch && srch_hit) |-> !mask[srch_ctx]);

  // R5: a search that finds nothing keeps the pointer
  a_r5_no_hit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (do_srch && !srch_hit) |=> $stable(cwp_q));

  // R11: the reserved op never moves the pointer
  a_r11_rsvd_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (op == SRCH_RSVD) |=> $stable(cwp_q));

  // R2: the window-within-context bits never change
  a_r2_window_parity: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(cwp_q[WIN_LSB-1:0]));

endmodule

// File: tb/sim_ctx_sched.sv
`timescale 1ns/1ps
module sim_ctx_sched;

  localparam int NC   = 4;
  localparam int CW   = 2;
  localparam int PW   = 3;
  localparam int CNTW = 4;
  localparam int DLY  = 4;
  localparam int CMAX = (1 << CNTW) - 1;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [1:0]      srch_op;
  logic            trap_dis;
  logic            sw_wr;
  logic [NC-1:0]   sw_mask;
  logic            rel_stb;
  logic [CW-1:0]   rel_ctx;
  logic [PW-1:0]   cwp;
  logic [NC-1:0]   mask;
  logic            idle;
  logic [CNTW-1:0] idle_cnt;

  always #4 clk = ~clk;

  ctx_sched #(
    .NUM_CTX (NC), .WIN_PER_CTX (2), .ENA_DELAY (DLY), .CNT_W (CNTW)
  ) u0 (
    .clk (clk), .rst_n (rst_n), .srch_op_i (srch_op), .trap_dis_i (trap_dis),
    .sw_wr_i (sw_wr), .sw_mask_i (sw_mask), .rel_stb_i (rel_stb),
    .rel_ctx_i (rel_ctx), .cwp_o (cwp), .mask_o (mask), .idle_o (idle),
    .idle_cnt_o (idle_cnt)
  );

  // behavioural reference state
  int m_mask, m_cwp, m_cnt, cyc;
  bit sp_v;
  int sp_val;
  int due_q[$];
  int dctx_q[$];
  int checks = 0, fails = 0;
  int wd = 0;
  bit done = 0;

  always @(posedge clk) begin
    wd++;
    if (wd > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog (R1..R11 unfinished) actual cycles=%0d expected below=%0d", wd, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic compare(input string tag);
    logic exp_idle;
    exp_idle = (m_mask == 15);
    checks++;
    if (cwp !== PW'(m_cwp) || mask !== NC'(m_mask) || idle !== exp_idle ||
        idle_cnt !== CNTW'(m_cnt)) begin
      fails++;
      $display("FAIL %s cyc=%0d actual cwp=%0d mask=%b idle=%b cnt=%0d expected cwp=%0d mask=%b idle=%b cnt=%0d",
               tag, cyc, cwp, mask, idle, idle_cnt, m_cwp, NC'(m_mask), exp_idle, m_cnt);
    end
  endtask

  task automatic step(input logic [1:0] op, input logic trap, input logic swr,
                      input logic [3:0] swm, input logic stb, input logic [1:0] sctx,
                      input string tag);
    int nm, ncwp, ncnt, cur;
    srch_op = op; trap_dis = trap; sw_wr = swr; sw_mask = swm;
    rel_stb = stb; rel_ctx = sctx;
    cur = m_cwp / 2;
    nm  = sp_v ? sp_val : m_mask;
    if (trap) nm = nm | (1 << cur);
    for (int i = 0; i < due_q.size(); i++)
      if (due_q[i] == cyc) nm = nm & ~(1 << dctx_q[i]);
    while (due_q.size() > 0 && due_q[0] <= cyc) begin
      void'(due_q.pop_front());
      void'(dctx_q.pop_front());
    end
    if (stb) begin
      due_q.push_back(cyc + DLY - 1);
      dctx_q.push_back(int'(sctx));
    end
    ncwp = m_cwp;
    if (op == 2'd1 || op == 2'd2) begin
      for (int k = 1; k < NC; k++) begin
        int c;
        c = (op == 2'd1) ? (cur + k) % NC : (cur - k + NC) % NC;
        if (((m_mask >> c) & 1) == 0) begin
          ncwp = c * 2 + (m_cwp % 2);
          break;
        end
      end
    end
    ncnt = m_cnt;
    if (m_mask == 15 && m_cnt < CMAX) ncnt = m_cnt + 1;
    @(posedge clk);
    m_mask = nm; m_cwp = ncwp; m_cnt = ncnt;
    sp_v = swr; sp_val = int'(swm);
    cyc++;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic wait_n(input int n, input string tag);
    for (int i = 0; i < n; i++) step(2'd0, 1'b0, 1'b0, 4'h0, 1'b0, 2'd0, tag);
  endtask

  initial begin
    rst_n = 1'b0; srch_op = '0; trap_dis = 1'b0; sw_wr = 1'b0; sw_mask = '0;
    rel_stb = 1'b0; rel_ctx = '0;
    m_mask = 0; m_cwp = 0; m_cnt = 0; cyc = 0; sp_v = 0; sp_val = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare("R1 reset");

    // R3 forward walk with wrap
    for (int i = 0; i < 4; i++) step(2'd1, 1'b0, 1'b0, 4'h0, 1'b0, 2'd0, "R3 fwd walk");
    // R4 backward walk with wrap
    step(2'd2, 1'b0, 1'b0, 4'h0, 1'b0, 2'd0, "R4 bwd wrap");
    step(2'd2, 1'b0, 1'b0, 4'h0, 1'b0, 2'd0, "R4 bwd");
    step(2'd1, 1'b0, 1'b0, 4'h0, 1'b0, 2'd0, "R3 fwd");
    // R7 software write with delay slot, R2 encoding
    step(2'd0, 1'b0, 1'b1, 4'b0101, 1'b0, 2'd0, "R7 sw write");
    step(2'd1, 1'b0, 1'b0, 4'h0, 1'b0, 2'd0, "R7 delay slot old mask");
    step(2'd1, 1'b0, 1'b0, 4'h0, 1'b0, 2'd0, "R7 R2 new mask skip");
    // R6 trap disables current
    step(2'd0, 1'b1, 1'b0, 4'h0, 1'b0, 2'd0, "R6 trap");
    step(2'd1, 1'b0, 1'b0, 4'h0, 1'b0, 2'd0, "R3 fwd skip disabled");
    step(2'd2, 1'b0, 1'b0, 4'h0, 1'b0, 2'd0, "R5 bwd none");
    step(2'd1, 1'b0, 1'b0, 4'h0, 1'b0, 2'd0, "R5 fwd none");
    // R10 all disabled
    step(2'd0, 1'b1, 1'b0, 4'h0, 1'b0, 2'd0, "R6 trap last");
    for (int i = 0; i < 3; i++) step(2'd1, 1'b0, 1'b0, 4'h0, 1'b0, 2'd0, "R10 R5 idle search");
    // R8 re-enable latency
    step(2'd0, 1'b0, 1'b0, 4'h0, 1'b1, 2'd2, "R8 strobe");
    wait_n(4, "R8 latency");
    step(2'd1, 1'b0, 1'b0, 4'h0, 1'b0, 2'd0, "R3 fwd to reenabled");
    // R9 re-enable beats trap
    step(2'd0, 1'b0, 1'b0, 4'h0, 1'b1, 2'd2, "R9 strobe");
    wait_n(2, "R9 wait");
    step(2'd0, 1'b1, 1'b0, 4'h0, 1'b0, 2'd0, "R9 trap collides");
    wait_n(2, "R9 after trap");
    // R9 re-enable beats software write
    step(2'd0, 1'b0, 1'b0, 4'h0, 1'b1, 2'd0, "R9 strobe sw");
    wait_n(1, "R9 wait sw");
    step(2'd0, 1'b0, 1'b1, 4'b1111, 1'b0, 2'd0, "R9 sw collides");
    wait_n(3, "R9 after sw");
    // R11 reserved op
    step(2'd3, 1'b0, 1'b0, 4'h0, 1'b0, 2'd0, "R11 reserved");
    step(2'd3, 1'b0, 1'b0, 4'h0, 1'b0, 2'd0, "R11 reserved");
    // R10 saturation
    step(2'd0, 1'b0, 1'b1, 4'b1111, 1'b0, 2'd0, "R10 sw all off");
    for (int i = 0; i < 20; i++) step(2'd2, 1'b0, 1'b0, 4'h0, 1'b0, 2'd0, "R10 R5 saturate");
    step(2'd0, 1'b0, 1'b0, 4'h0, 1'b1, 2'd1, "R8 strobe from idle");
    wait_n(5, "R8 R10 leave idle");
    step(2'd2, 1'b0, 1'b0, 4'h0, 1'b0, 2'd0, "R4 bwd to ctx1");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule